// File: doc/BRIEF.md
# Large Warp Sub-warp Packer

This block breaks the active-thread mask of a large warp into a stream of sub-warps that are each as wide as the SIMD datapath. The mask is a grid with `ROWS` rows and `LANES` columns, where `LANES` is the SIMD width. Each column feeds one SIMD lane. In every packing cycle the block takes one still-active thread from each column. The thread it takes is the one in the lowest-numbered row of that column. For each lane it reports whether a thread was found and the row it came from. It then clears the bits it took and repeats until no bits remain. One sub-warp can therefore collect threads from different rows, and draining the mask takes as many cycles as the fullest column has set bits.

The fetch stage loads a mask with a one-cycle `start_i` pulse while the block is idle. If `uncond_i` is set with the pulse, the instruction is an unconditional branch. In that case the block issues exactly one sub-warp and discards the rest of the mask, because only a single program-counter update is needed. The strobes `first_o` and `last_o` mark the first and the final sub-warp of a packet. `done_o` tells the fetch stage that the large warp may be considered again.

The controller has three named states. `ST_IDLE` waits for `start_i`. `ST_ISSUE` emits one sub-warp per cycle. `ST_FIN` raises `done_o` for one cycle. The transitions are:
- load-empty: `ST_IDLE` to `ST_FIN`, on a start with an all-zero mask.
- load: `ST_IDLE` to `ST_ISSUE`, on a start with a non-empty mask.
- drain: `ST_ISSUE` to `ST_ISSUE`, when set bits remain after the current pick.
- finish: `ST_ISSUE` to `ST_FIN`, when the current sub-warp is the last one.
- release: `ST_FIN` to `ST_IDLE`, unconditionally.

Top module: `subw_packer`

## Requirements
- R1: After reset `busy_o`, `sw_valid_o`, `done_o`, `first_o`, `last_o` and every bit of `lane_vld_o` are 0.
- R2: Mask bit `r*LANES + c` is the thread in row r, column c. In each issued sub-warp, `lane_vld_o[c]` is 1 exactly when column c of the remaining mask has a set bit. Row field c, at bits `c*ROW_W +: ROW_W` of `lane_row_o`, holds the lowest-numbered row whose bit is set in that column.
- R3: Bits that have been issued are removed from the remaining mask. Sub-warps are issued on consecutive cycles, starting the cycle after the accepted start. In normal mode the number of sub-warps equals the largest count of set bits in any one column.
- R4: `first_o` is 1 on the first sub-warp of a packet and 0 on every later one.
- R5: `last_o` is 1 on the sub-warp after which no set bits remain, and on no other sub-warp.
- R6: With `uncond_i` set at start and a non-empty mask, exactly one sub-warp is issued. Its lanes and rows follow R2 on the loaded mask, and both `first_o` and `last_o` are 1.
- R7: A start with an all-zero mask issues no sub-warp, and `done_o` is 1 in the cycle after the start.
- R8: `done_o` is a single-cycle pulse in the cycle after the last sub-warp. `busy_o` is 0 in the cycle after that.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored: the sub-warp sequence in progress is unchanged.
- R10: A lane whose `lane_vld_o` bit is 0, and every lane while `sw_valid_o` is 0, reports row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load `mask_i` and `uncond_i` when idle |
| uncond_i | input | 1 | Unconditional-branch mode: issue one sub-warp only |
| mask_i | input | ROWS*LANES | Active mask of the large warp, row-major |
| busy_o | output | 1 | A packet is being processed |
| sw_valid_o | output | 1 | A sub-warp is issued this cycle |
| lane_vld_o | output | LANES | Per-lane thread present |
| lane_row_o | output | LANES*ROW_W | Per-lane source row index |
| first_o | output | 1 | This is the first sub-warp of the packet |
| last_o | output | 1 | This is the final sub-warp of the packet |
| done_o | output | 1 | Packet finished; one-cycle pulse |

## Verification
The assertions assume that `start_i` is a clean, synchronous pulse and that `mask_i` and `uncond_i` are stable and known whenever `start_i` is high. They also assume the fetch stage waits for `done_o` before it expects a new packet to be accepted. Every stimulus is driven on the falling edge from tasks that hold the mask steady around the loading edge. The only start pulse given while busy is the one the ignore scenario injects on purpose, and it arrives while a packet is still draining.

// File: rtl/subw_pkg.sv
package subw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FIN   = 2'd2
    } subw_state_e;
endpackage

// File: rtl/subw_col_pick.sv
// Lowest-row priority pick within one column of the active mask.
module subw_col_pick #(
    parameter int ROWS  = 8,
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROWS-1:0]  col_i,
    output logic             found_o,
    output logic [ROW_W-1:0] row_o,
    output logic [ROWS-1:0]  pick_oh_o
);
    always_comb begin
        row_o     = '0;
        pick_oh_o = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (col_i[r]) begin
                row_o     = ROW_W'(r);
                pick_oh_o = ROWS'(1) << r;
            end
        end
    end

    assign found_o = |col_i;

    // R2: at most one bit is picked, and it is one that is still set
    assert_pick_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_oh_o) && ((pick_oh_o & ~col_i) == '0));

    // R2: nothing set below the reported row
    assert_pick_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> ((col_i & ((ROWS'(1) << row_o) - ROWS'(1))) == '0));
endmodule

// File: rtl/subw_mask_store.sv
// Remaining-thread mask: loaded once, then only ever cleared.
module subw_mask_store #(
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [MASK_W-1:0] load_mask_i,
    input  logic [MASK_W-1:0] clr_i,
    input  logic              flush_i,
    output logic [MASK_W-1:0] mask_o,
    output logic              empty_o,
    output logic              next_empty_o
);
    logic [MASK_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (load_i) begin
            mask_q <= load_mask_i;
        end else if (flush_i) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_q & ~clr_i;
        end
    end

    assign mask_o       = mask_q;
    assign empty_o      = (mask_q == '0);
    assign next_empty_o = ((mask_q & ~clr_i) == '0);

    // R3: without a load no new bit can appear
    assert_clear_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ((mask_q & ~$past(mask_q)) == '0));
endmodule

// File: rtl/subw_packer.sv
module subw_packer #(
    parameter int LANES = 4,
    parameter int ROWS  = 8,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int MASK_W = LANES * ROWS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   uncond_i,
    input  logic [MASK_W-1:0]      mask_i,
    output logic                   busy_o,
    output logic                   sw_valid_o,
    output logic [LANES-1:0]       lane_vld_o,
    output logic [LANES*ROW_W-1:0] lane_row_o,
    output logic                   first_o,
    output logic                   last_o,
    output logic                   done_o
);
    import subw_pkg::*;

    subw_state_e state_q, state_d;
    logic        uncond_q;
    logic        first_q;
    logic        accept;
    logic        issue;
    logic        last_hit;

    logic [MASK_W-1:0]      mask_q;
    logic [MASK_W-1:0]      pick_all;
    logic                   mask_empty;
    logic                   next_empty;
    logic [LANES-1:0]       col_found;
    logic [LANES*ROW_W-1:0] col_row;

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign issue    = (state_q == ST_ISSUE);
    assign last_hit = uncond_q || next_empty;

    subw_mask_store #(.MASK_W(MASK_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .load_mask_i (mask_i),
        .clr_i       (issue ? pick_all : '0),
        .flush_i     (issue && uncond_q),
        .mask_o      (mask_q),
        .empty_o     (mask_empty),
        .next_empty_o(next_empty)
    );

    // One picker per lane; each sees a column of the row-major mask
    for (genvar c = 0; c < LANES; c++) begin : g_lane
        logic [ROWS-1:0]  col;
        logic [ROWS-1:0]  oh;
        logic [ROW_W-1:0] row;
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign col[r]                = mask_q[r*LANES + c];
            assign pick_all[r*LANES + c] = oh[r];
        end
        subw_col_pick #(.ROWS(ROWS), .ROW_W(ROW_W)) u_pick (
            .clk      (clk),
            .rst_n    (rst_n),
            .col_i    (col),
            .found_o  (col_found[c]),
            .row_o    (row),
            .pick_oh_o(oh)
        );
        assign col_row[c*ROW_W +: ROW_W] = row;
    end

    // State register and packet flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            uncond_q <= 1'b0;
            first_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                uncond_q <= uncond_i;
                first_q  <= 1'b1;
            end else if (issue) begin
                first_q  <= 1'b0;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (mask_i == '0) ? ST_FIN : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (last_hit) begin
                    state_d = ST_FIN;
                end
            end
            ST_FIN: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        sw_valid_o = issue;
        done_o     = (state_q == ST_FIN);
        first_o    = issue && first_q;
        last_o     = issue && last_hit;
        lane_vld_o = issue ? col_found : '0;
        lane_row_o = '0;
        for (int c = 0; c < LANES; c++) begin
            if (issue && col_found[c]) begin
                lane_row_o[c*ROW_W +: ROW_W] = col_row[c*ROW_W +: ROW_W];
            end
        end
    end

    // R5: after the final sub-warp nothing remains
    assert_last_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid_o && last_o) |=> mask_empty);

    // R8: done lasts one cycle and the block is then idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R4: a sub-warp that is not the last is followed by one that is not first
    assert_first_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid_o && !last_o) |=> (sw_valid_o && !first_o));

    // R6: in unconditional mode the first sub-warp is followed by done
    assert_uncond_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid_o && first_o && uncond_q) |=> done_o);

    // R3: every issued sub-warp carries at least one thread
    assert_nonempty_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_valid_o |-> (lane_vld_o != '0));
endmodule

// File: tb/subw_packer_bench.sv
module subw_packer_bench;
    localparam int LANES  = 4;
    localparam int ROWS   = 8;
    localparam int ROW_W  = 3;
    localparam int MASK_W = LANES * ROWS;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start_i = 1'b0;
    logic                   uncond_i = 1'b0;
    logic [MASK_W-1:0]      mask_i = '0;
    logic                   busy_o, sw_valid_o, first_o, last_o, done_o;
    logic [LANES-1:0]       lane_vld_o;
    logic [LANES*ROW_W-1:0] lane_row_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    subw_packer #(.LANES(LANES), .ROWS(ROWS)) u_subw_packer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .uncond_i(uncond_i),
        .mask_i(mask_i), .busy_o(busy_o), .sw_valid_o(sw_valid_o),
        .lane_vld_o(lane_vld_o), .lane_row_o(lane_row_o),
        .first_o(first_o), .last_o(last_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int max_col_pop(input logic [MASK_W-1:0] m);
        int best = 0;
        for (int c = 0; c < LANES; c++) begin
            int n = 0;
            for (int r = 0; r < ROWS; r++) n += int'(m[r*LANES + c]);
            if (n > best) best = n;
        end
        return best;
    endfunction

    // Drives one packet and checks every sub-warp and the done pulse.
    task automatic run_packet(input logic [MASK_W-1:0] m, input bit unc, input bit inject);
        logic [MASK_W-1:0]      rem = m;
        logic [LANES-1:0]       ev;
        logic [LANES*ROW_W-1:0] er;
        int exp_cnt = unc ? ((m != '0) ? 1 : 0) : max_col_pop(m);
        int got = 0;
        bit fin = 1'b0;
        @(negedge clk);
        start_i = 1'b1; uncond_i = unc; mask_i = m;
        @(negedge clk);
        start_i = 1'b0; uncond_i = 1'b0; mask_i = '0;
        if (m == '0) begin
            chk(done_o === 1'b1 && sw_valid_o === 1'b0, "R7 empty mask done", {done_o, sw_valid_o}, 2'b10);
            @(negedge clk);
            chk(busy_o === 1'b0 && done_o === 1'b0, "R7 idle after empty", {busy_o, done_o}, 2'b00);
            return;
        end
        while (!fin && got < ROWS + 2) begin
            ev = '0; er = '0;
            for (int c = 0; c < LANES; c++) begin
                for (int r = ROWS - 1; r >= 0; r--) begin
                    if (rem[r*LANES + c]) begin
                        ev[c] = 1'b1;
                        er[c*ROW_W +: ROW_W] = ROW_W'(r);
                    end
                end
                if (ev[c]) rem[int'(er[c*ROW_W +: ROW_W])*LANES + c] = 1'b0;
            end
            if (unc) rem = '0;
            fin = (rem == '0);
            chk(sw_valid_o === 1'b1, "R3 consecutive issue", sw_valid_o, 1);
            chk(lane_vld_o === ev, "R2 lane valid", lane_vld_o, ev);
            chk(lane_row_o === er, "R2/R10 lane rows", lane_row_o, er);
            chk(first_o === (got == 0), unc ? "R6 first" : "R4 first strobe", first_o, got == 0);
            chk(last_o === fin, unc ? "R6 last" : "R5 last strobe", last_o, fin);
            got++;
            if (inject && got == 1) begin
                start_i = 1'b1; mask_i = ~m; uncond_i = 1'b1;  // R9 stray start
            end
            @(negedge clk);
            start_i = 1'b0; mask_i = '0; uncond_i = 1'b0;
        end
        chk(got == exp_cnt, inject ? "R9 count unchanged" : (unc ? "R6 single" : "R3 count"), got, exp_cnt);
        chk(done_o === 1'b1 && sw_valid_o === 1'b0 && lane_vld_o === '0 && lane_row_o === '0,
            "R8/R10 done pulse", {done_o, sw_valid_o, lane_vld_o}, 6'b100000);
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R8 idle after done", {done_o, busy_o}, 2'b00);
    endtask

    task automatic t_reset();
        chk(busy_o === 1'b0 && sw_valid_o === 1'b0 && done_o === 1'b0 && first_o === 1'b0 &&
            last_o === 1'b0 && lane_vld_o === '0, "R1 reset state",
            {busy_o, sw_valid_o, done_o, first_o, last_o, lane_vld_o}, 0);
    endtask

    task automatic t_dense();       run_packet('1, 1'b0, 1'b0); endtask
    task automatic t_staggered();   run_packet(32'h8421_1248, 1'b0, 1'b0); endtask
    task automatic t_one_column();  run_packet(32'h0202_2222, 1'b0, 1'b0); endtask
    task automatic t_single_bit();  run_packet(32'h0000_0400, 1'b0, 1'b0); endtask
    task automatic t_uncond();      run_packet(32'hF0F0_0C30, 1'b1, 1'b0); endtask
    task automatic t_empty();       run_packet('0, 1'b0, 1'b0); endtask
    task automatic t_empty_uncond();run_packet('0, 1'b1, 1'b0); endtask
    task automatic t_ignore_start();run_packet(32'h1357_9BDF, 1'b0, 1'b1); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dense();
        t_staggered();
        t_one_column();
        t_single_bit();
        t_uncond();
        t_empty();
        t_empty_uncond();
        t_ignore_start();
        t_staggered();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule